// File: doc/BRIEF.md
# IO Bank Freeze/Thaw Sequencer

This block is a hardware sequencer that moves the control lines of a set of IO channels between a frozen (safe, isolated) state and a thawed (operational) state. A single-cycle freeze or thaw request starts an ordered walk through the channels. The plain channels go first, in ascending index order. The last channel follows it. That channel carries extra calibration and delay-locked-loop controls and has a longer sequence.

Each step of a sequence drives a group of control lines and then waits a minimum time before the next step. The time is given in nanoseconds or in cycles of a slower internal oscillator. It is converted at elaboration into clock cycles from the clock frequency parameters. The thaw order is not the reverse of the freeze order. Thaw of the last channel contains a long calibration wait and a shorter settling wait. The block reports busy while a sequence runs, a one-cycle done pulse at its end, and a frozen flag for each channel.

Top module: `fz_ctrl`

## Requirements
- R1: After reset, every channel reports frozen (`frozen_o` all ones). Slew, pull-up, tristate, bus-hold and config-done outputs are all 0. Register reset, OCT reset and DLL reset are 1. Calibration start is 0. Busy and done are 0.
- R2: Freeze of a plain channel drives slew, pull-up and tristate to 0 in one cycle. Exactly S+1 cycles later it drives bus-hold and config-done to 0 and sets the channel's frozen bit in that same cycle.
- R3: Thaw of a plain channel drives bus-hold and config-done to 1. S+1 cycles later it drives pull-up and tristate to 1. S+1 cycles after that it drives slew to 1 and clears the frozen bit in that cycle.
- R4: Freeze of the last channel takes three steps, each 2 cycles apart: (a) slew, pull-up and tristate go to 0; (b) bus-hold and config-done go to 0 while register reset and OCT reset go to 1; (c) calibration start goes to 0 and DLL reset goes to 1, together with the frozen bit.
- R5: Thaw of the last channel first drops DLL reset. L+1 cycles later it raises calibration start. It then waits C cycles before its next step.
- R6: After the calibration wait, the last channel's thaw does the following: it raises bus-hold and config-done and drops OCT reset in one cycle. E+1 cycles later it raises pull-up and tristate. L+1 cycles later it drops register reset. L+1 cycles later it raises slew and clears the frozen bit.
- R7: Channels are handled in ascending index order, with the last channel after all the others. Each channel's first step comes 2 cycles after the previous channel's final step.
- R8: The wait constants are computed as N = max(1, ceil(value × clock rate / base rate)). S uses 20 ns and L uses 40 ns, each against 1000 MHz. C uses 1000 and E uses 33 oscillator cycles, against the oscillator rate. With the defaults (200 MHz clock, 30 MHz oscillator) the values are S=4, L=8, C=6667 and E=220. Two steps separated by a wait of N are exactly N+1 cycles apart.
- R9: Busy rises in the cycle after a request is accepted. It falls in the cycle of the final frozen-bit update. Requests that arrive while busy are ignored, so the running sequence keeps its length and its end state.
- R10: A freeze request while already frozen, or a thaw request while already thawed, still runs the full sequence with the same length. It ends in the same output state.
- R11: Done is high for exactly one cycle, the cycle of the final update, and busy is low in that cycle. When freeze and thaw are requested together while idle, freeze wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freeze_i | input | 1 | Freeze request pulse |
| thaw_i | input | 1 | Thaw request pulse |
| slew_o | output | NCH | Slew control per channel, 0 when frozen |
| pullup_o | output | NCH | Weak pull-up control per channel, 0 when frozen |
| tristate_o | output | NCH | Tristate control per channel, 0 when frozen |
| bushold_o | output | NCH | Bus-hold control per channel, 0 when frozen |
| cfgdone_o | output | NCH | Config-done per channel, 0 when frozen |
| regrst_o | output | 1 | Register reset of the last channel |
| octrst_o | output | 1 | OCT reset of the last channel |
| dllrst_o | output | 1 | DLL reset of the last channel |
| calstart_o | output | 1 | OCT calibration start of the last channel |
| frozen_o | output | NCH | Frozen status per channel |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
The hardest situation to reach is a request that lands in the middle of the last channel's long calibration wait. There the sequencer is thousands of cycles into a single step. A faulty design could restart the walk or reverse its direction. The stimulus starts a thaw, waits about 100 cycles until the plain channels are done and the calibration wait has begun, and then issues both a freeze and a thaw pulse. The bench then requires that the thaw completes with the same length it had when run alone. Exact step spacing is measured from the cycle at which each output line changes, which also exposes rounding errors in the oscillator-based wait.

// File: rtl/fz_pkg.sv
package fz_pkg;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_WAIT} st_e;

  typedef enum logic [2:0] {DLY_MIN, DLY_SHORT, DLY_LONG, DLY_CAL, DLY_SETTLE} dly_e;

  typedef struct packed {
    logic spt_lo;    // slew, pull-up, tristate low
    logic bhcfg_lo;
    logic bhcfg_hi;
    logic putri_hi;
    logic slew_hi;
    logic rrst_hi;
    logic rrst_lo;
    logic orst_hi;
    logic orst_lo;
    logic dll_hi;
    logic dll_lo;
    logic cal_hi;
    logic cal_lo;
    logic ch_end;    // last step of this channel
    dly_e dly;
  } act_t;

  function automatic int unsigned cyc_ceil(input int unsigned num, input int unsigned den);
    int unsigned r;
    r = (num + den - 1) / den;
    return (r < 1) ? 1 : r;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fz_timer.sv
module fz_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0)); // R8
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/fz_step_dec.sv
module fz_step_dec
  import fz_pkg::*;
(
  input  logic       thaw_i,
  input  logic       hv_i,
  input  logic [2:0] step_i,
  output act_t       act_o
);

  always_comb begin
    act_o = '0;
    unique case ({hv_i, thaw_i})
      2'b00: begin
        case (step_i)
          3'd0: begin act_o.spt_lo = 1'b1; act_o.dly = DLY_SHORT; end
          default: begin act_o.bhcfg_lo = 1'b1; act_o.ch_end = 1'b1; end
        endcase
      end
      2'b01: begin
        case (step_i)
          3'd0: begin act_o.bhcfg_hi = 1'b1; act_o.dly = DLY_SHORT; end
          3'd1: begin act_o.putri_hi = 1'b1; act_o.dly = DLY_SHORT; end
          default: begin act_o.slew_hi = 1'b1; act_o.ch_end = 1'b1; end
        endcase
      end
      2'b10: begin
        case (step_i)
          3'd0: act_o.spt_lo = 1'b1;
          3'd1: begin
            act_o.bhcfg_lo = 1'b1;
            act_o.rrst_hi  = 1'b1;
            act_o.orst_hi  = 1'b1;
          end
          default: begin
            act_o.cal_lo = 1'b1;
            act_o.dll_hi = 1'b1;
            act_o.ch_end = 1'b1;
          end
        endcase
      end
      default: begin
        case (step_i)
          3'd0: begin act_o.dll_lo = 1'b1; act_o.dly = DLY_LONG; end
          3'd1: begin act_o.cal_hi = 1'b1; act_o.dly = DLY_CAL; end
          3'd2: begin
            act_o.bhcfg_hi = 1'b1;
            act_o.orst_lo  = 1'b1;
            act_o.dly      = DLY_SETTLE;
          end
          3'd3: begin act_o.putri_hi = 1'b1; act_o.dly = DLY_LONG; end
          3'd4: begin act_o.rrst_lo = 1'b1; act_o.dly = DLY_LONG; end
          default: begin act_o.slew_hi = 1'b1; act_o.ch_end = 1'b1; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/fz_ctrl.sv
module fz_ctrl
  import fz_pkg::*;
#(
  parameter int unsigned NCH        = 4,
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned OSC_MHZ    = 30,
  parameter int unsigned SHORT_NS   = 20,
  parameter int unsigned LONG_NS    = 40,
  parameter int unsigned CAL_OSC    = 1000,
  parameter int unsigned SETTLE_OSC = 33
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           freeze_i,
  input  logic           thaw_i,
  output logic [NCH-1:0] slew_o,
  output logic [NCH-1:0] pullup_o,
  output logic [NCH-1:0] tristate_o,
  output logic [NCH-1:0] bushold_o,
  output logic [NCH-1:0] cfgdone_o,
  output logic           regrst_o,
  output logic           octrst_o,
  output logic           dllrst_o,
  output logic           calstart_o,
  output logic [NCH-1:0] frozen_o,
  output logic           busy_o,
  output logic           done_o
);

  localparam int unsigned D_SHORT  = cyc_ceil(SHORT_NS * CLK_MHZ, 1000);
  localparam int unsigned D_LONG   = cyc_ceil(LONG_NS * CLK_MHZ, 1000);
  localparam int unsigned D_CAL    = cyc_ceil(CAL_OSC * CLK_MHZ, OSC_MHZ);
  localparam int unsigned D_SETTLE = cyc_ceil(SETTLE_OSC * CLK_MHZ, OSC_MHZ);
  localparam int unsigned D_MAX    = umax(umax(D_SHORT, D_LONG), umax(D_CAL, D_SETTLE));
  localparam int unsigned TW       = $clog2(D_MAX + 1);
  localparam int unsigned CW       = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] HV_CH  = CW'(NCH - 1);

  st_e           st_q;
  logic          thaw_q;
  logic [CW-1:0] ch_q;
  logic [2:0]    step_q;
  logic          done_q;
  logic [NCH-1:0] slew_q, pu_q, tri_q, bh_q, cfg_q, frz_q;
  logic          rrst_q, orst_q, dll_q, cal_q;

  act_t          act;
  logic          hv;
  logic [TW-1:0] dly_val;
  logic          expire;

  assign hv = (ch_q == HV_CH);

  fz_step_dec u_dec (
    .thaw_i (thaw_q),
    .hv_i   (hv),
    .step_i (step_q),
    .act_o  (act)
  );

  always_comb begin
    case (act.dly)
      DLY_SHORT:  dly_val = TW'(D_SHORT);
      DLY_LONG:   dly_val = TW'(D_LONG);
      DLY_CAL:    dly_val = TW'(D_CAL);
      DLY_SETTLE: dly_val = TW'(D_SETTLE);
      default:    dly_val = TW'(1);
    endcase
  end

  fz_timer #(.W(TW)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (st_q == S_ACT),
    .val_i    (dly_val),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      thaw_q <= 1'b0;
      ch_q   <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      slew_q <= '0;
      pu_q   <= '0;
      tri_q  <= '0;
      bh_q   <= '0;
      cfg_q  <= '0;
      frz_q  <= '1;
      rrst_q <= 1'b1;
      orst_q <= 1'b1;
      dll_q  <= 1'b1;
      cal_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (freeze_i || thaw_i) begin
            st_q   <= S_ACT;
            thaw_q <= !freeze_i;  // freeze has priority
            ch_q   <= '0;
            step_q <= '0;
          end
        end
        S_ACT: begin
          if (act.spt_lo) begin
            slew_q[ch_q] <= 1'b0;
            pu_q[ch_q]   <= 1'b0;
            tri_q[ch_q]  <= 1'b0;
          end
          if (act.bhcfg_lo) begin bh_q[ch_q] <= 1'b0; cfg_q[ch_q] <= 1'b0; end
          if (act.bhcfg_hi) begin bh_q[ch_q] <= 1'b1; cfg_q[ch_q] <= 1'b1; end
          if (act.putri_hi) begin pu_q[ch_q] <= 1'b1; tri_q[ch_q] <= 1'b1; end
          if (act.slew_hi)  slew_q[ch_q] <= 1'b1;
          if (act.rrst_hi)  rrst_q <= 1'b1;
          if (act.rrst_lo)  rrst_q <= 1'b0;
          if (act.orst_hi)  orst_q <= 1'b1;
          if (act.orst_lo)  orst_q <= 1'b0;
          if (act.dll_hi)   dll_q  <= 1'b1;
          if (act.dll_lo)   dll_q  <= 1'b0;
          if (act.cal_hi)   cal_q  <= 1'b1;
          if (act.cal_lo)   cal_q  <= 1'b0;
          if (act.ch_end) begin
            frz_q[ch_q] <= !thaw_q;
            step_q      <= '0;
            if (hv) begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              ch_q <= ch_q + 1'b1;
              st_q <= S_WAIT;
            end
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= S_WAIT;
          end
        end
        default: if (expire) st_q <= S_ACT;
      endcase
    end
  end

  assign slew_o     = slew_q;
  assign pullup_o   = pu_q;
  assign tristate_o = tri_q;
  assign bushold_o  = bh_q;
  assign cfgdone_o  = cfg_q;
  assign regrst_o   = rrst_q;
  assign octrst_o   = orst_q;
  assign dllrst_o   = dll_q;
  assign calstart_o = cal_q;
  assign frozen_o   = frz_q;
  assign busy_o     = (st_q != S_IDLE);
  assign done_o     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(frozen_o) && $stable(slew_o) && $stable(bushold_o))); // R9
  AST_DLL_BEFORE_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(calstart_o) |-> !dllrst_o); // R5
  AST_CAL_BEFORE_BH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bushold_o[NCH-1]) |-> (calstart_o && !dllrst_o)); // R6

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    AST_SLEW_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(slew_o[k]) |-> (pullup_o[k] && bushold_o[k])); // R3
    if (k > 0) begin : g_ord
      AST_ORDER_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frozen_o[k]) |-> frozen_o[k-1]); // R7
      AST_ORDER_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(frozen_o[k]) |-> !frozen_o[k-1]); // R7
    end
  end

endmodule

// File: tb/sim_fz_ctrl.sv
`timescale 1ns/1ps
module sim_fz_ctrl;

  localparam int NCH = 4;
  localparam int E_S = (20 * 200 + 999) / 1000;   // 4
  localparam int E_L = (40 * 200 + 999) / 1000;   // 8
  localparam int E_C = (1000 * 200 + 29) / 30;    // 6667
  localparam int E_E = (33 * 200 + 29) / 30;      // 220

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic freeze_i = 1'b0, thaw_i = 1'b0;
  logic [NCH-1:0] slew_o, pullup_o, tristate_o, bushold_o, cfgdone_o, frozen_o;
  logic regrst_o, octrst_o, dllrst_o, calstart_o, busy_o, done_o;

  int checks = 0, errors = 0, cyc = 0;
  int t_slew[NCH], t_pu[NCH], t_tri[NCH], t_bh[NCH], t_cfg[NCH], t_frz[NCH];
  int t_reg, t_oct, t_dll, t_cal;
  logic [NCH-1:0] p_slew, p_pu, p_tri, p_bh, p_cfg, p_frz;
  logic p_reg, p_oct, p_dll, p_cal;
  int thaw_len, frz_len;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fz_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .freeze_i(freeze_i), .thaw_i(thaw_i),
    .slew_o(slew_o), .pullup_o(pullup_o), .tristate_o(tristate_o),
    .bushold_o(bushold_o), .cfgdone_o(cfgdone_o), .regrst_o(regrst_o),
    .octrst_o(octrst_o), .dllrst_o(dllrst_o), .calstart_o(calstart_o),
    .frozen_o(frozen_o), .busy_o(busy_o), .done_o(done_o)
  );

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (slew_o[c] !== p_slew[c]) t_slew[c] = cyc;
      if (pullup_o[c] !== p_pu[c]) t_pu[c] = cyc;
      if (tristate_o[c] !== p_tri[c]) t_tri[c] = cyc;
      if (bushold_o[c] !== p_bh[c]) t_bh[c] = cyc;
      if (cfgdone_o[c] !== p_cfg[c]) t_cfg[c] = cyc;
      if (frozen_o[c] !== p_frz[c]) t_frz[c] = cyc;
    end
    if (regrst_o !== p_reg) t_reg = cyc;
    if (octrst_o !== p_oct) t_oct = cyc;
    if (dllrst_o !== p_dll) t_dll = cyc;
    if (calstart_o !== p_cal) t_cal = cyc;
    p_slew = slew_o; p_pu = pullup_o; p_tri = tristate_o;
    p_bh = bushold_o; p_cfg = cfgdone_o; p_frz = frozen_o;
    p_reg = regrst_o; p_oct = octrst_o; p_dll = dllrst_o; p_cal = calstart_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_times();
    for (int c = 0; c < NCH; c++) begin
      t_slew[c] = -1; t_pu[c] = -1; t_tri[c] = -1;
      t_bh[c] = -1; t_cfg[c] = -1; t_frz[c] = -1;
    end
    t_reg = -1; t_oct = -1; t_dll = -1; t_cal = -1;
  endtask

  task automatic pulse(input logic f, input logic t);
    @(negedge clk); freeze_i = f; thaw_i = t;
    @(negedge clk); freeze_i = 1'b0; thaw_i = 1'b0;
  endtask

  // start a sequence, wait for done; returns cycles from acceptance to done
  task automatic run(input logic f, input logic t, input int mid, output int len);
    int st;
    int n;
    pulse(f, t);
    st = cyc;
    chk("R9 busy after request", int'(busy_o), 1);
    if (mid > 0) begin
      repeat (mid) @(negedge clk);
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
    end
    n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    len = cyc - st;
    chk("R11 done seen", int'(done_o), 1);
    chk("R9 busy low at done", int'(busy_o), 0);
    @(negedge clk);
    chk("R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic chk_frozen_state(input string req);
    chk({req, " frozen"}, int'(frozen_o), 4'hF);
    chk({req, " spt"}, int'({slew_o, pullup_o, tristate_o}), 0);
    chk({req, " bhcfg"}, int'({bushold_o, cfgdone_o}), 0);
    chk({req, " hv ctl"}, int'({regrst_o, octrst_o, dllrst_o, calstart_o}), 4'b1110);
  endtask

  task automatic chk_thawed_state(input string req);
    chk({req, " frozen"}, int'(frozen_o), 0);
    chk({req, " spt"}, int'({slew_o, pullup_o, tristate_o}), 12'hFFF);
    chk({req, " bhcfg"}, int'({bushold_o, cfgdone_o}), 8'hFF);
    chk({req, " hv ctl"}, int'({regrst_o, octrst_o, dllrst_o, calstart_o}), 4'b0001);
  endtask

  task automatic test_reset();
    chk_frozen_state("R1");
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
  endtask

  task automatic test_thaw();
    clear_times();
    run(1'b0, 1'b1, 0, thaw_len);
    for (int c = 0; c < NCH - 1; c++) begin
      chk("R3 cfg with bh", t_cfg[c], t_bh[c]);
      chk("R3 pu gap", t_pu[c] - t_bh[c], E_S + 1);
      chk("R3 tri with pu", t_tri[c], t_pu[c]);
      chk("R3 slew gap", t_slew[c] - t_pu[c], E_S + 1);
      chk("R3 thawed with slew", t_frz[c], t_slew[c]);
      if (c > 0) chk("R7 ascending thaw", t_bh[c] - t_frz[c-1], 2);
    end
    chk("R7 last ch after others", t_dll - t_frz[NCH-2], 2);
    chk("R5 cal gap", t_cal - t_dll, E_L + 1);
    chk("R8 cal wait rounding", t_bh[NCH-1] - t_cal, E_C + 1);
    chk("R6 cfg with bh", t_cfg[NCH-1], t_bh[NCH-1]);
    chk("R6 oct rst drop", t_oct, t_bh[NCH-1]);
    chk("R6 settle gap", t_pu[NCH-1] - t_bh[NCH-1], E_E + 1);
    chk("R6 tri with pu", t_tri[NCH-1], t_pu[NCH-1]);
    chk("R6 regrst gap", t_reg - t_pu[NCH-1], E_L + 1);
    chk("R6 slew gap", t_slew[NCH-1] - t_reg, E_L + 1);
    chk("R6 thawed with slew", t_frz[NCH-1], t_slew[NCH-1]);
    chk_thawed_state("R6 end");
  endtask

  task automatic test_freeze();
    clear_times();
    run(1'b1, 1'b0, 0, frz_len);
    for (int c = 0; c < NCH - 1; c++) begin
      chk("R2 pu with slew", t_pu[c], t_slew[c]);
      chk("R2 tri with slew", t_tri[c], t_slew[c]);
      chk("R2 bh gap", t_bh[c] - t_slew[c], E_S + 1);
      chk("R2 cfg with bh", t_cfg[c], t_bh[c]);
      chk("R2 frozen with bh", t_frz[c], t_bh[c]);
      if (c > 0) chk("R7 ascending freeze", t_slew[c] - t_frz[c-1], 2);
    end
    chk("R7 last ch freeze", t_slew[NCH-1] - t_frz[NCH-2], 2);
    chk("R4 step b gap", t_bh[NCH-1] - t_slew[NCH-1], 2);
    chk("R4 regrst with b", t_reg, t_bh[NCH-1]);
    chk("R4 octrst with b", t_oct, t_bh[NCH-1]);
    chk("R4 step c gap", t_dll - t_bh[NCH-1], 2);
    chk("R4 cal with dll", t_cal, t_dll);
    chk("R4 frozen with c", t_frz[NCH-1], t_dll);
    chk_frozen_state("R4 end");
  endtask

  task automatic test_repeat_freeze();
    int len;
    run(1'b1, 1'b0, 0, len);
    chk("R10 repeat freeze length", len, frz_len);
    chk_frozen_state("R10 repeat freeze");
  endtask

  task automatic test_busy_ignore();
    int len;
    run(1'b0, 1'b1, 100, len);
    chk("R9 thaw length unchanged", len, thaw_len);
    chk_thawed_state("R9 end");
  endtask

  task automatic test_repeat_thaw();
    int len;
    run(1'b0, 1'b1, 0, len);
    chk("R10 repeat thaw length", len, thaw_len);
    chk_thawed_state("R10 repeat thaw");
  endtask

  task automatic test_priority();
    int len;
    run(1'b1, 1'b1, 0, len);
    chk("R11 freeze priority length", len, frz_len);
    chk_frozen_state("R11 priority");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_times();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    test_thaw();
    test_freeze();
    test_repeat_freeze();
    test_thaw();
    test_busy_ignore();
    test_repeat_thaw();
    test_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule